// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block forms the second ALU operand of a 32-bit datapath in a single cycle. In register mode it takes a register value and shifts or rotates it by an amount that comes either from a 5-bit field in the instruction or from the low byte of another register. It also returns the carry that the shift produces. In immediate mode it builds the operand from an 8-bit constant rotated right by twice a 4-bit field. The ALU, the flag register and instruction decode sit outside the block. The block only returns the operand and the shifter carry.

The two amount sources treat a zero amount differently. An instruction-field amount of zero stands for a special case of each kind: a plain copy for left shift, a shift by the full word for the two right shifts, and a one-bit rotate through the carry for rotate. A register-supplied amount of zero always leaves both the value and the carry as they were. Register amounts beyond the word width follow saturating rules. The whole path is combinational. Its outputs follow its inputs within the same cycle.

Top module: `shf_operand_unit`

## Requirements
- R1: Kind code 0 (left shift) with an amount n from 1 to 31 moves zeros in at bit 0 and returns operand bit 32-n as carry.
- R2: Kind code 1 (logical right shift) with n from 1 to 31 fills the top bits with zeros and returns operand bit n-1 as carry. An instruction-field amount of 0 acts as a shift by 32: result 0, carry = operand bit 31.
- R3: Kind code 2 (arithmetic right shift) copies bit 31 into the vacated bits and returns operand bit n-1 as carry for n from 1 to 31. An instruction-field amount of 0, or a register amount of 32 or more, sets every result bit and the carry to operand bit 31.
- R4: Kind code 3 (rotate right) moves bit 0 into bit 31 and returns result bit 31 as carry. A nonzero register amount that is a multiple of 32 returns the operand unchanged, with carry = operand bit 31.
- R5: Kind code 3 with an instruction-field amount of 0 rotates right by one through the carry: result = {carry_in, operand[31:1]}, carry = operand bit 0.
- R6: Kind code 0 with an instruction-field amount of 0 returns the operand unchanged, with carry = carry_in.
- R7: A register amount of 0 returns the operand and carry_in unchanged for every kind code.
- R8: A register left shift by 32 gives 0 with carry = operand bit 0, and a register logical right shift by 32 gives 0 with carry = operand bit 31. Register amounts of 33 to 255 for these two kinds give 0 with carry 0.
- R9: In immediate mode the result is the 8-bit constant, zero-extended, rotated right by twice the 4-bit rotate field. The carry is result bit 31 when the field is nonzero and carry_in when it is zero. The register operand, kind and amount inputs have no effect in this mode.
- R10: Every amount from 0 to 255 produces its final result and carry in the same cycle as its inputs, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Register value to shift |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg_i | input | 1 | 1: amount from amt_reg_i, 0: amount from amt_imm_i |
| amt_imm_i | input | 5 | Instruction-field shift amount |
| amt_reg_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| use_imm_i | input | 1 | 1: build the operand from the rotated constant |
| imm_val_i | input | 8 | 8-bit constant |
| imm_rot_i | input | 4 | Rotate field; the rotate distance is twice its value |
| operand_o | output | 32 | Shifted or expanded operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bound checker watches all the zero and saturating cases in every cycle: register zero amounts, instruction-field left shift by zero, full-word arithmetic shifts, register shifts beyond 32, and the rotate-through-carry form. For any rotate it also checks that the count of ones is kept and that the carry equals result bit 31, and it checks the same bit-31 carry rule for immediate constants. The exact bit position of the carry for ordinary shift amounts, the exact rotate distance of an immediate constant, and the fact that unused inputs are ignored can only be shown by the bench. The bench compares each case against a model that shifts one bit at a time and against values worked out by hand.

// File: rtl/shf_pkg.sv
package shf_pkg;

   // Shift kind as carried on kind_i
   typedef enum logic [1:0] {
      SHK_LSL = 2'd0,
      SHK_LSR = 2'd1,
      SHK_ASR = 2'd2,
      SHK_ROR = 2'd3
   } shift_kind_e;

   // Operation after the amount source and the zero cases are resolved
   typedef enum logic [2:0] {
      SOP_PASS = 3'd0,
      SOP_LSL  = 3'd1,
      SOP_LSR  = 3'd2,
      SOP_ASR  = 3'd3,
      SOP_ROR  = 3'd4,
      SOP_RRX  = 3'd5
   } shift_op_e;

endpackage

// File: rtl/shf_rotator.sv
// Logarithmic right rotator: one mux stage per amount bit.
module shf_rotator #(
   parameter int DATA_W = 32,
   localparam int LOG2W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [LOG2W-1:0]  amt_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] stage [LOG2W+1];

   assign stage[0] = data_i;

   for (genvar gi = 0; gi < LOG2W; gi++) begin : g_stage
      localparam int K = 1 << gi;
      assign stage[gi+1] = amt_i[gi] ? {stage[gi][K-1:0], stage[gi][DATA_W-1:K]}
                                     : stage[gi];
   end

   assign data_o = stage[LOG2W];

endmodule

// File: rtl/shf_amount_norm.sv
// Resolves the amount source and maps the zero-amount cases to an operation.
module shf_amount_norm
   import shf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   localparam int LOG2W    = $clog2(DATA_W)
) (
   input  shift_kind_e          kind_i,
   input  logic                 from_reg_i,
   input  logic [LOG2W-1:0]     amt_imm_i,
   input  logic [REG_AMT_W-1:0] amt_reg_i,
   output shift_op_e            op_o,
   output logic [REG_AMT_W-1:0] amt_o
);

   shift_op_e kind_op;

   always_comb begin
      unique case (kind_i)
         SHK_LSL: kind_op = SOP_LSL;
         SHK_LSR: kind_op = SOP_LSR;
         SHK_ASR: kind_op = SOP_ASR;
         default: kind_op = SOP_ROR;
      endcase
   end

   always_comb begin
      op_o  = kind_op;
      amt_o = from_reg_i ? amt_reg_i : REG_AMT_W'(amt_imm_i);
      if (from_reg_i) begin
         if (amt_reg_i == '0) op_o = SOP_PASS;
      end else if (amt_imm_i == '0) begin
         unique case (kind_i)
            SHK_LSL: op_o = SOP_PASS;
            SHK_ROR: op_o = SOP_RRX;
            default: amt_o = REG_AMT_W'(DATA_W);
         endcase
      end
   end

endmodule

// File: rtl/shf_core.sv
// Shift datapath: each kind is computed over a one-bit-wider word whose extra bit holds the carry.
module shf_core
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   localparam int LOG2W = $clog2(DATA_W)
) (
   input  shift_op_e         op_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] data_o,
   output logic              carry_o
);

   logic [DATA_W:0]   lsl_w;
   logic [DATA_W:0]   lsr_w;
   logic [DATA_W:0]   asr_w;
   logic [DATA_W-1:0] ror_w;

   // shifts by the word width or more leave zeros (or sign copies for asr)
   assign lsl_w = {1'b0, data_i} << amt_i;
   assign lsr_w = {data_i, 1'b0} >> amt_i;
   assign asr_w = $signed({data_i, 1'b0}) >>> amt_i;

   shf_rotator #(.DATA_W(DATA_W)) i_rot (
      .data_i (data_i),
      .amt_i  (amt_i[LOG2W-1:0]),
      .data_o (ror_w)
   );

   always_comb begin
      unique case (op_i)
         SOP_LSL: begin
            data_o  = lsl_w[DATA_W-1:0];
            carry_o = lsl_w[DATA_W];
         end
         SOP_LSR: begin
            data_o  = lsr_w[DATA_W:1];
            carry_o = lsr_w[0];
         end
         SOP_ASR: begin
            data_o  = asr_w[DATA_W:1];
            carry_o = asr_w[0];
         end
         SOP_ROR: begin
            data_o  = ror_w;
            carry_o = ror_w[DATA_W-1];
         end
         SOP_RRX: begin
            data_o  = {carry_i, data_i[DATA_W-1:1]};
            carry_o = data_i[0];
         end
         default: begin
            data_o  = data_i;
            carry_o = carry_i;
         end
      endcase
   end

endmodule

// File: rtl/shf_imm_expand.sv
// Expands a small constant rotated right by twice its rotate field.
module shf_imm_expand #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   localparam int LOG2W = $clog2(DATA_W)
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [ROT_W-1:0]  rot_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] data_o,
   output logic              carry_o
);

   logic [DATA_W-1:0] ext_w;
   logic [LOG2W-1:0]  dist_w;

   assign ext_w  = {{(DATA_W-IMM_W){1'b0}}, imm_i};
   assign dist_w = LOG2W'({rot_i, 1'b0});

   shf_rotator #(.DATA_W(DATA_W)) i_rot (
      .data_i (ext_w),
      .amt_i  (dist_w),
      .data_o (data_o)
   );

   assign carry_o = (rot_i == '0) ? carry_i : data_o[DATA_W-1];

endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit
   import shf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   localparam int LOG2W    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]    operand_i,
   input  logic [1:0]           kind_i,
   input  logic                 amt_from_reg_i,
   input  logic [LOG2W-1:0]     amt_imm_i,
   input  logic [REG_AMT_W-1:0] amt_reg_i,
   input  logic                 carry_i,
   input  logic                 use_imm_i,
   input  logic [IMM_W-1:0]     imm_val_i,
   input  logic [ROT_W-1:0]     imm_rot_i,
   output logic [DATA_W-1:0]    operand_o,
   output logic                 carry_o
);

   // elaboration-time parameter checks
   if ((1 << LOG2W) != DATA_W) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (REG_AMT_W <= LOG2W) begin : g_bad_amt
      $error("REG_AMT_W must hold the value DATA_W");
   end
   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("IMM_W must be narrower than DATA_W");
   end
   if (ROT_W + 1 > LOG2W) begin : g_bad_rot
      $error("twice the rotate field must stay below DATA_W");
   end

   shift_op_e            sop;
   logic [REG_AMT_W-1:0] samt;
   logic [DATA_W-1:0]    sh_data;
   logic                 sh_carry;
   logic [DATA_W-1:0]    im_data;
   logic                 im_carry;

   shf_amount_norm #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) i_norm (
      .kind_i     (shift_kind_e'(kind_i)),
      .from_reg_i (amt_from_reg_i),
      .amt_imm_i  (amt_imm_i),
      .amt_reg_i  (amt_reg_i),
      .op_o       (sop),
      .amt_o      (samt)
   );

   shf_core #(.DATA_W(DATA_W), .AMT_W(REG_AMT_W)) i_core (
      .op_i    (sop),
      .amt_i   (samt),
      .data_i  (operand_i),
      .carry_i (carry_i),
      .data_o  (sh_data),
      .carry_o (sh_carry)
   );

   shf_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) i_imm (
      .imm_i   (imm_val_i),
      .rot_i   (imm_rot_i),
      .carry_i (carry_i),
      .data_o  (im_data),
      .carry_o (im_carry)
   );

   assign operand_o = use_imm_i ? im_data  : sh_data;
   assign carry_o   = use_imm_i ? im_carry : sh_carry;

endmodule

// File: rtl/shf_operand_unit_chk.sv
module shf_operand_unit_chk #(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   localparam int LOG2W    = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0]    operand_i,
   input logic [1:0]           kind_i,
   input logic                 amt_from_reg_i,
   input logic [LOG2W-1:0]     amt_imm_i,
   input logic [REG_AMT_W-1:0] amt_reg_i,
   input logic                 carry_i,
   input logic                 use_imm_i,
   input logic [IMM_W-1:0]     imm_val_i,
   input logic [ROT_W-1:0]     imm_rot_i,
   input logic [DATA_W-1:0]    operand_o,
   input logic                 carry_o
);

   logic sh_mode, reg_amt, fld_zero, ror_moves;

   always_comb begin
      sh_mode   = !use_imm_i;
      reg_amt   = sh_mode && amt_from_reg_i;
      fld_zero  = sh_mode && !amt_from_reg_i && (amt_imm_i == '0);
      ror_moves = sh_mode && (kind_i == 2'd3) &&
                  (amt_from_reg_i ? (amt_reg_i != '0) : (amt_imm_i != '0));

      // R7
      reg_zero_pass_chk: assert (!(reg_amt && amt_reg_i == '0) ||
                                 (operand_o == operand_i && carry_o == carry_i))
         else $error("register amount zero altered operand or carry");

      // R6
      fld_lsl_zero_chk: assert (!(fld_zero && kind_i == 2'd0) ||
                                (operand_o == operand_i && carry_o == carry_i))
         else $error("field left shift by zero altered operand or carry");

      // R8
      reg_over_width_chk: assert (!(reg_amt && kind_i[1] == 1'b0 &&
                                    int'(amt_reg_i) > DATA_W) ||
                                  (operand_o == '0 && carry_o == 1'b0))
         else $error("register shift beyond width not cleared");

      // R3
      asr_full_chk: assert (!(sh_mode && kind_i == 2'd2 &&
                              (fld_zero || (reg_amt && int'(amt_reg_i) >= DATA_W))) ||
                            (operand_o == {DATA_W{operand_i[DATA_W-1]}} &&
                             carry_o == operand_i[DATA_W-1]))
         else $error("full arithmetic shift not sign filled");

      // R4
      ror_ones_chk: assert (!ror_moves ||
                            ($countones(operand_o) == $countones(operand_i) &&
                             carry_o == operand_o[DATA_W-1]))
         else $error("rotate lost bits or carry differs from bit 31");

      // R5
      rrx_chk: assert (!(fld_zero && kind_i == 2'd3) ||
                       (operand_o == {carry_i, operand_i[DATA_W-1:1]} &&
                        carry_o == operand_i[0]))
         else $error("rotate through carry mismatch");

      // R9
      imm_ones_chk: assert (!use_imm_i ||
                            $countones(operand_o) == $countones(imm_val_i))
         else $error("immediate expansion lost bits");

      // R9
      imm_carry_chk: assert (!(use_imm_i && imm_rot_i != '0) ||
                             carry_o == operand_o[DATA_W-1])
         else $error("immediate carry differs from bit 31");
   end

endmodule

bind shf_operand_unit shf_operand_unit_chk #(
   .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) i_shf_operand_unit_chk (
   .operand_i      (operand_i),
   .kind_i         (kind_i),
   .amt_from_reg_i (amt_from_reg_i),
   .amt_imm_i      (amt_imm_i),
   .amt_reg_i      (amt_reg_i),
   .carry_i        (carry_i),
   .use_imm_i      (use_imm_i),
   .imm_val_i      (imm_val_i),
   .imm_rot_i      (imm_rot_i),
   .operand_o      (operand_o),
   .carry_o        (carry_o)
);

// File: tb/test_shf_operand_unit.sv
module test_shf_operand_unit;

   logic        clk = 1'b0;
   logic [31:0] operand_i = '0;
   logic [1:0]  kind_i = '0;
   logic        amt_from_reg_i = 1'b0;
   logic [4:0]  amt_imm_i = '0;
   logic [7:0]  amt_reg_i = '0;
   logic        carry_i = 1'b0;
   logic        use_imm_i = 1'b0;
   logic [7:0]  imm_val_i = '0;
   logic [3:0]  imm_rot_i = '0;
   logic [31:0] operand_o;
   logic        carry_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   shf_operand_unit i_shf_operand_unit (
      .operand_i      (operand_i),
      .kind_i         (kind_i),
      .amt_from_reg_i (amt_from_reg_i),
      .amt_imm_i      (amt_imm_i),
      .amt_reg_i      (amt_reg_i),
      .carry_i        (carry_i),
      .use_imm_i      (use_imm_i),
      .imm_val_i      (imm_val_i),
      .imm_rot_i      (imm_rot_i),
      .operand_o      (operand_o),
      .carry_o        (carry_o)
   );

   // bit-serial model: one step per bit position
   task automatic model(output logic [31:0] r, output logic c);
      int n;
      logic [31:0] v;
      v = operand_i;
      c = carry_i;
      if (use_imm_i) begin
         v = {24'd0, imm_val_i};
         for (int i = 0; i < 2 * int'(imm_rot_i); i++) v = {v[0], v[31:1]};
         c = (imm_rot_i == 0) ? carry_i : v[31];
         r = v;
         return;
      end
      n = amt_from_reg_i ? int'(amt_reg_i) : int'(amt_imm_i);
      if (!amt_from_reg_i && n == 0) begin
         if (kind_i == 2'd1 || kind_i == 2'd2) n = 32;
         else if (kind_i == 2'd3) begin
            r = {carry_i, operand_i[31:1]};
            c = operand_i[0];
            return;
         end
      end
      for (int i = 0; i < n; i++) begin
         case (kind_i)
            2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
            2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
            2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      r = v;
   endtask

   task automatic drive(input logic [1:0] k, input logic fr, input logic [4:0] ai,
                        input logic [7:0] ar, input logic [31:0] op, input logic ci);
      @(negedge clk);
      use_imm_i = 1'b0; kind_i = k; amt_from_reg_i = fr;
      amt_imm_i = ai; amt_reg_i = ar; operand_i = op; carry_i = ci;
      #1;
   endtask

   task automatic expect_val(input string req, input logic [31:0] er, input logic ec);
      checks++;
      if (operand_o !== er || carry_o !== ec) begin
         errors++;
         $display("FAIL %s: got %h/%b expected %h/%b", req, operand_o, carry_o, er, ec);
      end
   endtask

   task automatic expect_model(input string req);
      logic [31:0] er;
      logic ec;
      model(er, ec);
      expect_val(req, er, ec);
   endtask

   task automatic t_idle;
      drive(2'd0, 1'b0, 5'd0, 8'd0, 32'h0, 1'b0);
      expect_val("R6 idle", 32'h0, 1'b0);
   endtask

   task automatic t_lsl;
      drive(2'd0, 1'b0, 5'd4, 8'd0, 32'hF000_000F, 1'b0);
      expect_val("R1 lsl4", 32'h0000_00F0, 1'b1);
      drive(2'd0, 1'b1, 5'd0, 8'd1, 32'h8000_0001, 1'b0);
      expect_val("R1 lsl1 reg", 32'h0000_0002, 1'b1);
      drive(2'd0, 1'b0, 5'd31, 8'd0, 32'h0000_0003, 1'b1);
      expect_val("R1 lsl31", 32'h8000_0000, 1'b1);
   endtask

   task automatic t_lsr;
      drive(2'd1, 1'b0, 5'd1, 8'd0, 32'h8000_0003, 1'b0);
      expect_val("R2 lsr1", 32'h4000_0001, 1'b1);
      drive(2'd1, 1'b0, 5'd0, 8'd0, 32'h8000_0000, 1'b0);
      expect_val("R2 lsr field0 is 32", 32'h0, 1'b1);
   endtask

   task automatic t_asr;
      drive(2'd2, 1'b0, 5'd4, 8'd0, 32'h8000_0000, 1'b1);
      expect_val("R3 asr4", 32'hF800_0000, 1'b0);
      drive(2'd2, 1'b1, 5'd0, 8'd40, 32'h8000_0000, 1'b0);
      expect_val("R3 asr reg40", 32'hFFFF_FFFF, 1'b1);
      drive(2'd2, 1'b0, 5'd0, 8'd0, 32'h7FFF_FFFF, 1'b1);
      expect_val("R3 asr field0", 32'h0, 1'b0);
   endtask

   task automatic t_ror;
      drive(2'd3, 1'b0, 5'd1, 8'd0, 32'h0000_0001, 1'b0);
      expect_val("R4 ror1", 32'h8000_0000, 1'b1);
      drive(2'd3, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
      expect_val("R4 ror reg32", 32'h8000_0000, 1'b1);
      drive(2'd3, 1'b1, 5'd0, 8'd36, 32'h0000_00F3, 1'b0);
      expect_val("R4 ror reg36", 32'h3000_000F, 1'b0);
   endtask

   task automatic t_rrx;
      drive(2'd3, 1'b0, 5'd0, 8'd0, 32'h0000_0003, 1'b0);
      expect_val("R5 rrx c0", 32'h0000_0001, 1'b1);
      drive(2'd3, 1'b0, 5'd0, 8'd0, 32'h0000_0002, 1'b1);
      expect_val("R5 rrx c1", 32'h8000_0001, 1'b0);
   endtask

   task automatic t_zero;
      drive(2'd0, 1'b0, 5'd0, 8'd0, 32'hDEAD_BEEF, 1'b1);
      expect_val("R6 lsl field0", 32'hDEAD_BEEF, 1'b1);
      for (int k = 0; k < 4; k++) begin
         drive(2'(k), 1'b1, 5'd7, 8'd0, 32'h8765_4321, 1'(k & 1));
         expect_val("R7 reg amount zero", 32'h8765_4321, 1'(k & 1));
      end
   endtask

   task automatic t_reg_edge;
      drive(2'd0, 1'b1, 5'd0, 8'd32, 32'h0000_0001, 1'b0);
      expect_val("R8 lsl reg32", 32'h0, 1'b1);
      drive(2'd1, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
      expect_val("R8 lsr reg32", 32'h0, 1'b1);
      drive(2'd0, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1);
      expect_val("R8 lsl reg33", 32'h0, 1'b0);
      drive(2'd1, 1'b1, 5'd0, 8'd200, 32'hFFFF_FFFF, 1'b1);
      expect_val("R8 lsr reg200", 32'h0, 1'b0);
   endtask

   task automatic imm(input logic [7:0] v, input logic [3:0] r, input logic ci);
      @(negedge clk);
      use_imm_i = 1'b1; imm_val_i = v; imm_rot_i = r; carry_i = ci;
      #1;
   endtask

   task automatic t_imm;
      imm(8'hFF, 4'd0, 1'b1);
      expect_val("R9 imm rot0", 32'h0000_00FF, 1'b1);
      imm(8'hFF, 4'd4, 1'b0);
      expect_val("R9 imm rot8", 32'hFF00_0000, 1'b1);
      imm(8'h01, 4'd1, 1'b1);
      expect_val("R9 imm rot2", 32'h4000_0000, 1'b0);
      imm(8'h02, 4'd15, 1'b1);
      expect_val("R9 imm rot30", 32'h0000_0008, 1'b0);
      // register-path inputs must not matter in immediate mode
      operand_i = 32'hFFFF_FFFF; kind_i = 2'd3; amt_from_reg_i = 1'b1; amt_reg_i = 8'd5;
      #1;
      expect_val("R9 imm ignores operand", 32'h0000_0008, 1'b0);
      for (int r = 0; r < 16; r++) begin
         imm(8'hA5, 4'(r), 1'(r & 1));
         expect_model("R9 imm sweep");
      end
   endtask

   task automatic t_sweep;
      logic [31:0] pats [3] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hFFFF_0000};
      for (int p = 0; p < 3; p++) begin
         for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 41; a++) begin
               drive(2'(k), 1'b1, 5'd0, 8'(a), pats[p], 1'(a & 1));
               expect_model("R10 reg sweep");
            end
            drive(2'(k), 1'b1, 5'd0, 8'd255, pats[p], 1'b1);
            expect_model("R10 reg 255");
            for (int a = 0; a < 32; a++) begin
               drive(2'(k), 1'b0, 5'(a), 8'd0, pats[p], 1'(p & 1));
               expect_model("R1 R2 R3 R4 field sweep");
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      t_idle();
      t_lsl();
      t_lsr();
      t_asr();
      t_ror();
      t_rrx();
      t_zero();
      t_reg_edge();
      t_imm();
      t_sweep();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule